// File: doc/BRIEF.md
# Write-Protected Presence-Detect Serial Memory

This block is a 256-byte two-wire (I2C) slave memory that holds a module's configuration bytes. Its 7-bit bus address is the fixed class code `1010` followed by three strap inputs. A bus master can write single bytes, and it can read from any address by sending a word address first and then a repeated start. It can also read from the current address pointer. Reads continue byte after byte while the master acknowledges, and the pointer wraps from the top of the array back to zero.

The lower half of the array (addresses 0 to 127) can never be written. The upper half (128 to 255) accepts writes only while the protect input is low. When a write that changed the array is closed by a stop condition, the block enters a write cycle of `WR_CYCLES` system clocks. For that whole period it refuses to acknowledge its own address. At reset the array is loaded from a computed pattern. A scanner then sums bytes 0 to 62 and compares the low 8 bits of that sum with byte 63, reporting whether the stored checksum is consistent.

The bus lines are oversampled by the system clock, so SCL must be much slower than the system clock. The SDA output is open-drain: `sda_oe` high pulls the line low.

Top module: `spd_eeprom_slave`

## Requirements
- R1: The slave acknowledges (pulls SDA low during the ninth clock) only an address byte whose upper seven bits equal `1010` followed by `addr_sel`, with the R/W flag in bit 0 (1 means read). Any other address byte is not acknowledged, and the slave ignores the bus until the next start.
- R2: A data byte written to an address of 128 or above while `wp_i` is low is stored, and it is returned by a later read of that address.
- R3: A data byte written to an address below 128 is acknowledged but not stored, and it does not start a write cycle.
- R4: A data byte written to an address of 128 or above while `wp_i` is high is acknowledged but not stored, and it does not start a write cycle.
- R5: A random read works as follows. The master sends an address byte with the write flag, then a word address, then a repeated start and an address byte with the read flag. The slave then returns the byte at that word address.
- R6: During a read, each byte the master acknowledges is followed by the byte at the next address, with 255 wrapping to 0. A master NACK ends the read.
- R7: After a stop that closes a transaction in which at least one byte was stored, the slave acknowledges no address byte for `WR_CYCLES` system clocks. After that it acknowledges again.
- R8: The slave acknowledges every word-address and data byte it receives. It sends read data MSB first and releases SDA during the master's acknowledge bit. SDA changes only while SCL is low.
- R9: After reset, `csum_done` rises once the scan ends. `csum_bad` is then high exactly when byte 63 differs from the low 8 bits of the sum of bytes 0 to 62, and `csum_bad` is never high without `csum_done`.
- R10: While and right after reset, `sda_oe`, `csum_done` and `csum_bad` are low. The array holds (i*INIT_MUL + INIT_ADD) mod 256 at each address i other than 63, and byte 63 holds the checksum plus `CSUM_SKEW`.
- R11: A read that starts with an address byte carrying the read flag, with no word address, continues from the address after the last byte transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; reloads the array |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | Pull SDA low when high (open-drain drive) |
| addr_sel | input | 3 | Strap bits forming the low bits of the slave address |
| wp_i | input | 1 | High blocks writes to the upper half |
| csum_done | output | 1 | Checksum scan finished |
| csum_bad | output | 1 | Stored checksum does not match the computed one |

## Verification
The bound checker watches four properties on every cycle:
- the array is written only in the upper half, and only when the protect input was low the cycle before;
- a write cycle begins only right after a stop is detected;
- the slave never drives SDA while a write cycle runs, and its drive changes only while the synchronised SCL is low;
- the checksum flag never appears before the scan has finished.

Some behaviour can only be shown by the bench's bus transactions: which bytes are acknowledged, that protected writes leave the data unchanged and leave the address answered immediately, the wrap of a sequential read, current-address reads, and the actual checksum verdict on a consistent array and on a deliberately skewed one.

// File: rtl/spd_pkg.sv
package spd_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_ACKDEV, S_WADDR, S_ACKWA,
    S_WDATA, S_ACKWR, S_RDATA, S_MACK
  } bus_st_e;

  // pattern byte for a given address
  function automatic logic [7:0] base_byte(int idx, int mul, int add);
    logic [31:0] t;
    t = idx * mul + add;
    return t[7:0];
  endfunction

  // low 8 bits of the sum of pattern bytes below pos, plus a skew
  function automatic logic [7:0] csum_byte(int mul, int add, int pos, int skew);
    logic [7:0]  s;
    logic [31:0] k;
    s = '0;
    for (int j = 0; j < pos; j++) s = s + base_byte(j, mul, add);
    k = skew;
    return s + k[7:0];
  endfunction

endpackage

// File: rtl/spd_bus_edge.sv
module spd_bus_edge (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_m, sda_m, scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_d <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m; scl_d <= scl_s;
      sda_m <= sda_i; sda_s <= sda_m; sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/spd_mem.sv
module spd_mem #(
  parameter int AW        = 8,
  parameter int CSUM_POS  = 63,
  parameter int INIT_MUL  = 37,
  parameter int INIT_ADD  = 11,
  parameter int CSUM_SKEW = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_we,
  input  logic [AW-1:0] a_waddr,
  input  logic [7:0]    a_wdata,
  input  logic [AW-1:0] a_raddr,
  output logic [7:0]    a_rdata,
  input  logic [AW-1:0] b_raddr,
  output logic [7:0]    b_rdata
);
  localparam int         DEPTH    = 1 << AW;
  localparam logic [7:0] CSUM_VAL = spd_pkg::csum_byte(INIT_MUL, INIT_ADD, CSUM_POS, CSUM_SKEW);

  logic [7:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++)
        ram[i] <= (i == CSUM_POS) ? CSUM_VAL : spd_pkg::base_byte(i, INIT_MUL, INIT_ADD);
    end else if (a_we) begin
      ram[a_waddr] <= a_wdata;
    end
  end

  always_ff @(posedge clk) begin
    a_rdata <= ram[a_raddr];
    b_rdata <= ram[b_raddr];
  end
endmodule

// File: rtl/spd_csum.sv
module spd_csum #(
  parameter int AW       = 8,
  parameter int CSUM_POS = 63
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          done,
  output logic          bad
);
  localparam logic [AW-1:0] CPOS = AW'(CSUM_POS);

  logic [AW-1:0] idx, idx_d;
  logic          scan, scan_d;
  logic [7:0]    acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0; idx_d <= '0; scan <= 1'b1; scan_d <= 1'b0;
      acc <= '0; done <= 1'b0; bad <= 1'b0;
    end else begin
      scan_d <= scan;
      idx_d  <= idx;
      if (scan) begin
        if (idx == CPOS) scan <= 1'b0;
        else             idx  <= idx + 1'b1;
      end
      if (scan_d) begin
        if (idx_d == CPOS) begin
          done <= 1'b1;
          bad  <= (acc != rd_data);
        end else begin
          acc <= acc + rd_data;
        end
      end
    end
  end

  assign rd_addr = idx;
endmodule

// File: rtl/spd_eeprom_slave.sv
module spd_eeprom_slave #(
  parameter int         AW        = 8,
  parameter int         WR_CYCLES = 750000,
  parameter int         CSUM_POS  = 63,
  parameter int         INIT_MUL  = 37,
  parameter int         INIT_ADD  = 11,
  parameter int         CSUM_SKEW = 0,
  parameter logic [3:0] DEV_CLASS = 4'b1010
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] addr_sel,
  input  logic       wp_i,
  output logic       csum_done,
  output logic       csum_bad
);
  import spd_pkg::*;

  localparam int CW = $clog2(WR_CYCLES + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  bus_st_e       st;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg, rd_q, scan_q;
  logic [AW-1:0] ptr, wr_addr, scan_addr;
  logic [7:0]    wr_data;
  logic          rw, more, pend, wr_en, busy, load_now;
  logic [CW-1:0] busy_cnt;

  spd_bus_edge u_edge (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  spd_mem #(.AW(AW), .CSUM_POS(CSUM_POS), .INIT_MUL(INIT_MUL),
            .INIT_ADD(INIT_ADD), .CSUM_SKEW(CSUM_SKEW)) u_mem (
    .clk(clk), .rst(rst), .a_we(wr_en), .a_waddr(wr_addr), .a_wdata(wr_data),
    .a_raddr(ptr), .a_rdata(rd_q), .b_raddr(scan_addr), .b_rdata(scan_q)
  );

  spd_csum #(.AW(AW), .CSUM_POS(CSUM_POS)) u_csum (
    .clk(clk), .rst(rst), .rd_addr(scan_addr), .rd_data(scan_q),
    .done(csum_done), .bad(csum_bad)
  );

  assign busy     = (busy_cnt != '0);
  assign load_now = (st == S_ACKDEV && rw) || (st == S_MACK && more);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; bitcnt <= '0; shreg <= '0; ptr <= '0; rw <= 1'b0;
      more <= 1'b0; pend <= 1'b0; sda_oe <= 1'b0; wr_en <= 1'b0;
      wr_addr <= '0; wr_data <= '0; busy_cnt <= '0;
    end else begin
      wr_en <= 1'b0;
      if (busy) busy_cnt <= busy_cnt - CW'(1);
      if (stop_det) begin
        st <= S_IDLE;
        sda_oe <= 1'b0;
        if (pend) begin
          busy_cnt <= CW'(WR_CYCLES);
          pend <= 1'b0;
        end
      end else if (start_det) begin
        st <= S_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (scl_rise) begin
        case (st)
          S_DEV, S_WADDR, S_WDATA: begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end
          S_MACK:  more <= ~sda_s;
          default: ;
        endcase
      end else if (scl_fall) begin
        if (load_now) begin
          shreg  <= rd_q;
          sda_oe <= ~rd_q[7];
          bitcnt <= 4'd1;
          ptr    <= ptr + 1'b1;
          st     <= S_RDATA;
        end else begin
          case (st)
            S_DEV: if (bitcnt == 4'd8) begin
              if (shreg[7:1] == {DEV_CLASS, addr_sel} && !busy) begin
                sda_oe <= 1'b1;
                rw     <= shreg[0];
                st     <= S_ACKDEV;
              end else begin
                st <= S_IDLE;
              end
            end
            S_ACKDEV: begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              st     <= S_WADDR;
            end
            S_WADDR: if (bitcnt == 4'd8) begin
              ptr    <= shreg[AW-1:0];
              sda_oe <= 1'b1;
              st     <= S_ACKWA;
            end
            S_WDATA: if (bitcnt == 4'd8) begin
              if (ptr[AW-1] && !wp_i) begin
                wr_en   <= 1'b1;
                wr_addr <= ptr;
                wr_data <= shreg;
                pend    <= 1'b1;
              end
              ptr    <= ptr + 1'b1;
              sda_oe <= 1'b1;
              st     <= S_ACKWR;
            end
            S_ACKWA, S_ACKWR: begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              st     <= S_WDATA;
            end
            S_RDATA: if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              st     <= S_MACK;
            end else begin
              sda_oe <= ~shreg[6];
              shreg  <= {shreg[6:0], 1'b0};
              bitcnt <= bitcnt + 4'd1;
            end
            S_MACK: begin
              sda_oe <= 1'b0;
              st     <= S_IDLE;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/spd_eeprom_chk.sv
module spd_eeprom_chk (
  input logic clk,
  input logic rst,
  input logic sda_oe,
  input logic scl_s,
  input logic busy,
  input logic stop_det,
  input logic wr_en,
  input logic wr_top,
  input logic wp_i,
  input logic csum_done,
  input logic csum_bad
);
  // R3
  lower_half_locked_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wr_top);

  // R4
  protect_pin_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(!wp_i));

  // R7
  busy_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_det));

  // R7
  silent_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_oe);

  // R8
  drive_on_low_scl_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_s);

  // R9
  flag_after_scan_chk: assert property (@(posedge clk) disable iff (rst)
    csum_bad |-> csum_done);
endmodule

bind spd_eeprom_slave spd_eeprom_chk u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .scl_s(scl_s), .busy(busy),
  .stop_det(stop_det), .wr_en(wr_en), .wr_top(wr_addr[AW-1]), .wp_i(wp_i),
  .csum_done(csum_done), .csum_bad(csum_bad)
);

// File: tb/sim_spd_eeprom_slave.sv
module sim_spd_eeprom_slave;
  localparam int         Q    = 4;
  localparam int         WRC  = 300;
  localparam int         MUL  = 37;
  localparam int         ADD  = 11;
  localparam logic [7:0] DEVW = {4'b1010, 3'b101, 1'b0};
  localparam logic [7:0] DEVR = {4'b1010, 3'b101, 1'b1};

  typedef struct {
    logic [7:0] v;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst, scl_m, sda_m, wp, sda_oe, csum_done, csum_bad;
  logic u1_oe, u1_done, u1_bad;
  logic sda_line;
  int   n_chk = 0, n_bad = 0;
  bit   ended = 0;
  exp_t exp_q[$];
  logic [7:0] got_q[$];
  exp_t e;
  logic [7:0] g;

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  spd_eeprom_slave #(.WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(3'b101), .wp_i(wp), .csum_done(csum_done), .csum_bad(csum_bad));

  spd_eeprom_slave #(.WR_CYCLES(WRC), .CSUM_SKEW(1)) u1 (
    .clk(clk), .rst(rst), .scl_i(1'b1), .sda_i(1'b1), .sda_oe(u1_oe),
    .addr_sel(3'b000), .wp_i(1'b0), .csum_done(u1_done), .csum_bad(u1_bad));

  function automatic logic [7:0] ref_byte(int i);
    int s = 0;
    if (i != 63) return 8'(i * MUL + ADD);
    for (int j = 0; j < 63; j++) s += (j * MUL + ADD) & 255;
    return 8'(s);
  endfunction

  task automatic push_exp(logic [7:0] v, string tag);
    exp_t x;
    x.v = v; x.tag = tag;
    exp_q.push_back(x);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0 && got_q.size() > 0) begin
      e = exp_q.pop_front();
      g = got_q.pop_front();
      n_chk++;
      if (g !== e.v) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", e.tag, g, e.v);
      end
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(2 * Q);
  endtask

  task automatic bit_out(logic b);
    sda_m = b; tick(Q); scl_m = 1; tick(2 * Q); scl_m = 0; tick(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); b = sda_line; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic send_chk(logic [7:0] b, logic exp_ack, string tag);
    logic a;
    push_exp({7'd0, exp_ack}, tag);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    got_q.push_back({7'd0, a});
  endtask

  task automatic recv_chk(logic [7:0] exp_v, logic m_ack, string tag);
    logic [7:0] d;
    logic b;
    push_exp(exp_v, tag);
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(!m_ack);
    got_q.push_back(d);
  endtask

  task automatic set_ptr(logic [7:0] a, string tag);
    bus_start(); send_chk(DEVW, 0, tag); send_chk(a, 0, "R8");
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      n_bad += exp_q.size();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    rst = 1; scl_m = 1; sda_m = 1; wp = 0;
    tick(5);
    // R10 reset state
    push_exp(0, "R10 sda_oe"); got_q.push_back({7'd0, sda_oe});
    push_exp(0, "R10 done");   got_q.push_back({7'd0, csum_done});
    rst = 0;
    tick(1);
    push_exp(0, "R10 bad");    got_q.push_back({7'd0, csum_bad});
    tick(120);
    // R9 checksum verdicts
    push_exp(1, "R9 done");      got_q.push_back({7'd0, csum_done});
    push_exp(0, "R9 good");      got_q.push_back({7'd0, csum_bad});
    push_exp(1, "R9 skewed");    got_q.push_back({7'd0, u1_bad});

    // R1 wrong strap bits and wrong class code
    bus_start(); send_chk({4'b1010, 3'b000, 1'b0}, 1, "R1 strap"); bus_stop();
    bus_start(); send_chk({4'b1011, 3'b101, 1'b0}, 1, "R1 class"); bus_stop();

    // R5 random read, R6 sequential continuation
    set_ptr(8'h05, "R1 match");
    bus_start(); send_chk(DEVR, 0, "R5");
    recv_chk(ref_byte(5), 1, "R5");
    recv_chk(ref_byte(6), 1, "R6");
    recv_chk(ref_byte(7), 0, "R6");
    bus_stop();

    // R2 upper write, R7 busy window
    set_ptr(8'h90, "R2"); send_chk(8'hA5, 0, "R2"); bus_stop();
    bus_start(); send_chk(DEVW, 1, "R7 busy nack"); bus_stop();
    tick(WRC + 50);
    set_ptr(8'h90, "R7 ack again");
    bus_start(); send_chk(DEVR, 0, "R2"); recv_chk(8'hA5, 0, "R2 readback"); bus_stop();

    // R3 lower half locked, no busy
    set_ptr(8'h10, "R3"); send_chk(~ref_byte(16), 0, "R3 acked"); bus_stop();
    set_ptr(8'h10, "R3 no busy");
    bus_start(); send_chk(DEVR, 0, "R3"); recv_chk(ref_byte(16), 0, "R3 unchanged"); bus_stop();

    // R4 protect pin high
    wp = 1;
    set_ptr(8'h91, "R4"); send_chk(8'hEE, 0, "R4 acked"); bus_stop();
    set_ptr(8'h91, "R4 no busy");
    bus_start(); send_chk(DEVR, 0, "R4"); recv_chk(ref_byte(145), 0, "R4 unchanged"); bus_stop();
    wp = 0;

    // R6 wrap from top of array
    set_ptr(8'hFE, "R6");
    bus_start(); send_chk(DEVR, 0, "R6");
    recv_chk(ref_byte(254), 1, "R6");
    recv_chk(ref_byte(255), 1, "R6 top");
    recv_chk(ref_byte(0), 0, "R6 wrap");
    bus_stop();

    // R11 current-address read
    bus_start(); send_chk(DEVR, 0, "R11"); recv_chk(ref_byte(1), 0, "R11"); bus_stop();

    // R10 checksum byte content as seen on the bus
    set_ptr(8'd63, "R10");
    bus_start(); send_chk(DEVR, 0, "R10"); recv_chk(ref_byte(63), 0, "R10 csum byte"); bus_stop();

    tick(20);
    finish_run();
  end
endmodule